// File: doc/BRIEF.md
# Video-Mode Display Timing Generator

This block produces horizontal sync, vertical sync and data-enable for a video-mode display link. It also passes a 24-bit pixel stream from an upstream source to the link. Software loads the timing through a small write port. A horizontal counter marks the position inside a line. A second counter walks every pixel clock of the frame as one linear index. All vertical boundaries (sync length, first and last active position) are therefore pixel indices within the frame and not line numbers.

Pixels enter on a valid/ready stream. The block raises `pix_ready` only during cycles whose position is inside the active window. Upstream must hold `pix_valid` and `pix_data` steady while `pix_ready` is low; outside the window nothing is consumed. The fill colour replaces upstream data when recovery is on and data is missing inside the window.

All timing, polarity and fill settings go to a shadow copy. That copy moves to the working set at the end of a frame, and continuously while the block is idle. Starting takes effect on the next clock. Stopping waits for the running frame to finish. Every output is registered, so frame position p appears on the outputs two cycles after the clock edge that accepts the enabling write, plus p.

Top module: `video_timing_gen`

## Requirements
- R1: During and after reset, with no enable written, `vid_hsync`, `vid_vsync`, `vid_de`, `frame_irq` and `pix_ready` are 0 and `vid_pixel` is 0.
- R2: Register 1 holds the line length in pixels in bits [11:0] and the hsync width in bits [27:16]. The horizontal count starts at 0 at each frame start, wraps after line length − 1, and hsync is active while the count is below the width.
- R3: Register 3 holds the frame length in pixel clocks and register 4 holds the vsync length in pixel clocks. Vsync is active while the frame index is below the vsync length, and the frame index wraps to 0 after frame length − 1.
- R4: Register 2 holds the first active column in bits [11:0] and the last in bits [27:16]. Registers 5 and 6 hold the first and last active frame index. `vid_de` is 1 exactly when both counts lie inside these inclusive bounds.
- R5: Register 7 holds a skew that is added to both vertical bounds of the active window.
- R6: Register 8 bit 0 makes hsync active-low and bit 1 makes vsync active-low. While idle, both syncs sit at their inactive level under these bits.
- R7: `pix_ready` is 1 only in cycles whose position is inside the active window. A pixel accepted there appears on `vid_pixel` one cycle later, together with `vid_de`.
- R8: Register 9 holds a fill colour in bits [23:0] and a recovery enable in bit 31. Inside the window with `pix_valid` low, `vid_pixel` shows the fill colour if recovery is on and 0 if it is off. Outside the window `vid_pixel` is 0.
- R9: Writing 1 to register 0 bit 0 starts the frame at index 0 on the next clock. Writing 0 lets the running frame finish, after which both counters rest at 0.
- R10: `frame_irq` is a one-cycle pulse shown together with the last pixel of every frame, including the last frame before a stop.
- R11: A timing write made mid-frame leaves the running frame unchanged and takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Upstream pixel present |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| pix_data | input | 24 | Upstream pixel |
| vid_hsync | output | 1 | Horizontal sync, programmed polarity |
| vid_vsync | output | 1 | Vertical sync, programmed polarity |
| vid_de | output | 1 | Data enable |
| vid_pixel | output | 24 | Outgoing pixel |
| frame_irq | output | 1 | End-of-frame pulse |

## Verification
The end of a frame is the cycle where several things happen together. In that cycle the frame interrupt fires, the shadow settings move to the working set, and a pending stop takes effect. The bench writes the stop in the middle of a frame that already runs under newly loaded active-low polarity and skew. It then checks three things: output continues to the final pixel, the pulse appears with that final pixel, and the next cycle shows both syncs at their active-low idle levels. A second overlap is an underflow inside the window at the same point where the ready signal begins. This is provoked by dropping `pix_valid` at a window edge and judging `pix_ready` and the filled pixel cycle by cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 32;
  localparam int HI_LSB = 16;
  localparam int RECOVER_BIT = 31;

  typedef enum logic [CFG_AW-1:0] {
    A_ENABLE = 4'd0,
    A_LINE   = 4'd1,
    A_HWIN   = 4'd2,
    A_FRAME  = 4'd3,
    A_VSLEN  = 4'd4,
    A_VFIRST = 4'd5,
    A_VLAST  = 4'd6,
    A_SKEW   = 4'd7,
    A_POL    = 4'd8,
    A_FILL   = 4'd9
  } cfg_addr_e;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int PW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  input  logic              load,
  output logic              en_req,
  output logic [HW-1:0]     line_len,
  output logic [HW-1:0]     hs_width,
  output logic [HW-1:0]     h_first,
  output logic [HW-1:0]     h_last,
  output logic [FW-1:0]     frame_len,
  output logic [FW-1:0]     vs_len,
  output logic [FW-1:0]     v_first,
  output logic [FW-1:0]     v_last,
  output logic [FW-1:0]     skew,
  output logic              hs_low,
  output logic              vs_low,
  output logic [PW-1:0]     fill,
  output logic              recover
);
  localparam int SW = 4*HW + 5*FW + 3 + PW;

  logic [HW-1:0] s_line, s_hsw, s_hfirst, s_hlast;
  logic [FW-1:0] s_frame, s_vslen, s_vfirst, s_vlast, s_skew;
  logic [1:0]    s_pol;
  logic [PW-1:0] s_fill;
  logic          s_rec;
  logic [SW-1:0] shadow_bus, active_bus;
  logic          unused_bits;

  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_req   <= 1'b0;
      s_line   <= '0;
      s_hsw    <= '0;
      s_hfirst <= '0;
      s_hlast  <= '0;
      s_frame  <= '0;
      s_vslen  <= '0;
      s_vfirst <= '0;
      s_vlast  <= '0;
      s_skew   <= '0;
      s_pol    <= '0;
      s_fill   <= '0;
      s_rec    <= 1'b0;
    end else if (we) begin
      case (addr)
        A_ENABLE: en_req <= wdata[0];
        A_LINE: begin
          s_line <= wdata[HW-1:0];
          s_hsw  <= wdata[HI_LSB+HW-1:HI_LSB];
        end
        A_HWIN: begin
          s_hfirst <= wdata[HW-1:0];
          s_hlast  <= wdata[HI_LSB+HW-1:HI_LSB];
        end
        A_FRAME:  s_frame  <= wdata[FW-1:0];
        A_VSLEN:  s_vslen  <= wdata[FW-1:0];
        A_VFIRST: s_vfirst <= wdata[FW-1:0];
        A_VLAST:  s_vlast  <= wdata[FW-1:0];
        A_SKEW:   s_skew   <= wdata[FW-1:0];
        A_POL:    s_pol    <= wdata[1:0];
        A_FILL: begin
          s_fill <= wdata[PW-1:0];
          s_rec  <= wdata[RECOVER_BIT];
        end
        default: ;
      endcase
    end
  end

  assign shadow_bus = {s_line, s_hsw, s_hfirst, s_hlast,
                       s_frame, s_vslen, s_vfirst, s_vlast, s_skew,
                       s_pol, s_fill, s_rec};

  always_ff @(posedge clk) begin
    if (!rst_n) active_bus <= '0;
    else if (load) active_bus <= shadow_bus;
  end

  assign {line_len, hs_width, h_first, h_last,
          frame_len, vs_len, v_first, v_last, skew,
          vs_low, hs_low, fill, recover} = active_bus;
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_req,
  input  logic [HW-1:0] line_len,
  input  logic [FW-1:0] frame_len,
  output logic          run,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] fcnt,
  output logic          wrap,
  output logic          load
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [FW-1:0] F_ONE = FW'(1);

  logic line_end;

  assign wrap     = run && (fcnt == frame_len - F_ONE);
  assign line_end = (hcnt == line_len - H_ONE);
  assign load     = !run || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hcnt <= '0;
      fcnt <= '0;
    end else if (!run) begin
      run  <= en_req;
      hcnt <= '0;
      fcnt <= '0;
    end else if (wrap) begin
      run  <= en_req;
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + F_ONE;
      hcnt <= line_end ? '0 : hcnt + H_ONE;
    end
  end
endmodule

// File: rtl/vtg_out.sv
module vtg_out #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wrap,
  input  logic [HW-1:0] hcnt,
  input  logic [FW-1:0] fcnt,
  input  logic [HW-1:0] hs_width,
  input  logic [HW-1:0] h_first,
  input  logic [HW-1:0] h_last,
  input  logic [FW-1:0] vs_len,
  input  logic [FW-1:0] v_first,
  input  logic [FW-1:0] v_last,
  input  logic [FW-1:0] skew,
  input  logic          hs_low,
  input  logic          vs_low,
  input  logic [PW-1:0] fill,
  input  logic          recover,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_data,
  output logic          pix_ready,
  output logic          vid_hsync,
  output logic          vid_vsync,
  output logic          vid_de,
  output logic [PW-1:0] vid_pixel,
  output logic          frame_irq
);
  logic [FW-1:0] v_lo, v_hi;
  logic          in_h, in_v, win;
  logic [PW-1:0] next_pix;

  assign v_lo = v_first + skew;
  assign v_hi = v_last + skew;
  assign in_h = (hcnt >= h_first) && (hcnt <= h_last);
  assign in_v = (fcnt >= v_lo) && (fcnt <= v_hi);
  assign win  = run && in_h && in_v;
  assign pix_ready = win;

  always_comb begin
    next_pix = '0;
    if (win) begin
      if (pix_valid)    next_pix = pix_data;
      else if (recover) next_pix = fill;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_hsync <= 1'b0;
      vid_vsync <= 1'b0;
      vid_de    <= 1'b0;
      vid_pixel <= '0;
      frame_irq <= 1'b0;
    end else begin
      vid_hsync <= (run && (hcnt < hs_width)) ^ hs_low;
      vid_vsync <= (run && (fcnt < vs_len)) ^ vs_low;
      vid_de    <= win;
      vid_pixel <= next_pix;
      frame_irq <= wrap;
    end
  end
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int PW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PW-1:0]     pix_data,
  output logic              vid_hsync,
  output logic              vid_vsync,
  output logic              vid_de,
  output logic [PW-1:0]     vid_pixel,
  output logic              frame_irq
);
  logic          en_req, load, run, wrap;
  logic [HW-1:0] line_len, hs_width, h_first, h_last, hcnt;
  logic [FW-1:0] frame_len, vs_len, v_first, v_last, skew, fcnt;
  logic          hs_low, vs_low, recover;
  logic [PW-1:0] fill;

  vtg_regs #(.HW(HW), .FW(FW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load), .en_req(en_req),
    .line_len(line_len), .hs_width(hs_width), .h_first(h_first), .h_last(h_last),
    .frame_len(frame_len), .vs_len(vs_len), .v_first(v_first), .v_last(v_last),
    .skew(skew), .hs_low(hs_low), .vs_low(vs_low), .fill(fill), .recover(recover)
  );

  vtg_counters #(.HW(HW), .FW(FW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .line_len(line_len),
    .frame_len(frame_len), .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .wrap(wrap), .load(load)
  );

  vtg_out #(.HW(HW), .FW(FW), .PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap), .hcnt(hcnt), .fcnt(fcnt),
    .hs_width(hs_width), .h_first(h_first), .h_last(h_last),
    .vs_len(vs_len), .v_first(v_first), .v_last(v_last), .skew(skew),
    .hs_low(hs_low), .vs_low(vs_low), .fill(fill), .recover(recover),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_de(vid_de),
    .vid_pixel(vid_pixel), .frame_irq(frame_irq)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int FW = 24,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          wrap,
  input logic [FW-1:0] fcnt,
  input logic          pix_ready,
  input logic          vid_de,
  input logic [PW-1:0] vid_pixel,
  input logic          frame_irq
);
  localparam logic [FW-1:0] F_ONE = FW'(1);

  // R9
  idle_no_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !vid_de);

  // R7
  ready_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> run);

  // R8
  blank_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_de |-> (vid_pixel == '0));

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  // R3
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (fcnt == $past(fcnt) + F_ONE));
endmodule

bind video_timing_gen vtg_checker #(.FW(FW), .PW(PW)) u_vtg_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap), .fcnt(fcnt),
  .pix_ready(pix_ready), .vid_de(vid_de), .vid_pixel(vid_pixel),
  .frame_irq(frame_irq)
);

// File: tb/video_timing_gen_test.sv
`timescale 1ns/1ps
module video_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [23:0] pix_data = '0;
  logic        vid_hsync, vid_vsync, vid_de, frame_irq;
  logic [23:0] vid_pixel;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int en_cyc = 0;
  bit done = 1'b0;

  localparam int FLEN = 60;
  localparam logic [23:0] PIX = 24'h123456;
  localparam logic [23:0] FILLC = 24'h0000FF;
  // {pos[7:0], hsync, vsync, de, irq} for frame 0, active-high polarity
  localparam logic [11:0] VEC [15] = '{
    12'h00C, 12'h01C, 12'h024, 12'h094, 12'h0A8,
    12'h130, 12'h170, 12'h182, 12'h1C2, 12'h1D0,
    12'h1E8, 12'h302, 12'h360, 12'h3A0, 12'h3B1
  };

  video_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
    .vid_de(vid_de), .vid_pixel(vid_pixel), .frame_irq(frame_irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_out(input int f, input int p);
    int target;
    target = en_cyc + 2 + f*FLEN + p;
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 reset outs", {vid_hsync, vid_vsync, vid_de, frame_irq, pix_ready}, 0);
    check("R1 reset pixel", vid_pixel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_write(4'd1, (32'd2 << 16) | 32'd10);
    cfg_write(4'd2, (32'd8 << 16) | 32'd4);
    cfg_write(4'd3, 32'd60);
    cfg_write(4'd4, 32'd10);
    cfg_write(4'd5, 32'd20);
    cfg_write(4'd6, 32'd49);
    cfg_write(4'd7, 32'd0);
    cfg_write(4'd8, 32'd0);
    cfg_write(4'd9, 32'h8000_0000 | 32'(FILLC));
    repeat (2) @(negedge clk);
    // R1 idle after configuration, no enable yet
    check("R1 idle outs", {vid_hsync, vid_vsync, vid_de, frame_irq, pix_ready}, 0);
    pix_valid = 1'b1; pix_data = PIX;
    cfg_write(4'd0, 32'd1);
    en_cyc = cyc;

    // R2 R3 R4 R7 R10: frame 0 vector walk
    for (int i = 0; i < 15; i++) begin
      wait_out(0, int'(VEC[i][11:4]));
      check("R2/R3/R4/R10 frame0 vector", {vid_hsync, vid_vsync, vid_de, frame_irq}, VEC[i][3:0]);
      check("R7 frame0 pixel", vid_pixel, VEC[i][1] ? PIX : 24'h0);
    end

    // R7 ready edge and R8 underflow fill
    wait_out(1, 0);  pix_valid = 1'b0;
    wait_out(1, 22); check("R7 ready before window", pix_ready, 0);
    wait_out(1, 23); check("R7 ready at window start", pix_ready, 1);
    wait_out(1, 24); check("R8 fill on underflow", {vid_de, vid_pixel}, {1'b1, FILLC});
    wait_out(1, 30); pix_valid = 1'b1;
    wait_out(1, 44); check("R7 pixel passes", vid_pixel, PIX);
    cfg_write(4'd9, 32'(FILLC));

    // R11 mid-frame window change, R8 no recovery
    wait_out(2, 1);
    cfg_write(4'd2, (32'd3 << 16) | 32'd2);
    pix_valid = 1'b0;
    wait_out(2, 24); check("R11 old window kept", vid_de, 1);
    check("R8 zero without recovery", vid_pixel, 0);
    pix_valid = 1'b1;
    wait_out(3, 22); check("R11 new window start", vid_de, 1);
    wait_out(3, 24); check("R11 old column gone", vid_de, 0);
    cfg_write(4'd8, 32'd3);

    // R6 polarity
    wait_out(4, 0);  check("R6 both active low", {vid_hsync, vid_vsync}, 2'b00);
    wait_out(4, 5);  check("R6 hsync inactive high", vid_hsync, 1);
    wait_out(4, 20); check("R6 vsync inactive high", vid_vsync, 1);
    cfg_write(4'd7, 32'd10);

    // R5 skew moves vertical window to [30,59]
    wait_out(5, 22); check("R5 skewed window not yet", vid_de, 0);
    wait_out(5, 32); check("R5 skewed window active", {vid_de, vid_pixel}, {1'b1, PIX});
    cfg_write(4'd0, 32'd0);

    // R9 deferred stop, R10 last pulse
    wait_out(5, 40); check("R9 still running", vid_hsync, 0);
    wait_out(5, 59); check("R10 final irq", frame_irq, 1);
    wait_out(6, 0);  check("R9 idle levels", {vid_hsync, vid_vsync, vid_de, frame_irq}, 4'b1100);
    wait_out(6, 30); check("R9 held idle", {vid_hsync, vid_vsync, pix_ready}, 3'b110);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule